// File: doc/BRIEF.md
# Serial Control-Register Slave

This block is a four-wire serial slave. It lets an external host write and read a small bank of 10-bit control registers. The host drives a chip-select (active low), a serial clock and a data input. The block returns read data on a data output that it drives only during a read. The pad ring builds the tri-state output from `spi_dout` and `spi_dout_oe`. The block passes register contents to neighbouring logic on parallel outputs. Address 3 holds only a single sense-enable flag. A read of address 3 also returns the live level of an external comparator.

The serial pins are asynchronous to the system clock. They pass through a synchronizer of `SYNC_STAGES` flops and are then edge-detected in the system clock domain. A frame sends a direction flag first, then two address bits, then ten data bits, all most significant bit first. A write is held back until chip-select rises. If the frame was cut short, it leaves no trace.

A frame state machine sequences each transfer:
- `ST_IDLE` waits for chip-select to go low, then takes transition `SEL_LOW` to `ST_HDR`.
- `ST_HDR` collects the flag and the address. On the third bit it takes either `HDR_WRITE` to `ST_WDATA` or `HDR_READ` to `ST_RDATA`.
- `ST_WDATA` shifts in the write data. On the thirteenth bit it takes `WR_FULL` to `ST_WFULL`.
- `ST_WFULL` ignores any further clocks until chip-select rises.
- `ST_RDATA` shifts the read word out. On the falling edge after the last bit it takes `RD_DONE` to `ST_RDONE`.
- `ST_RDONE` waits with the output released.
- From any state, chip-select high takes `DESELECT` back to `ST_IDLE`. When that happens in `ST_WFULL`, the write is committed.

Top module: `ser_reg_slave`

## Requirements
- R1: After reset, `ctl_reg0`, `ctl_reg1`, `ctl_reg2` and `sense_en` are all 0, and `spi_dout_oe` is 0.
- R2: A write frame is a 0 flag, then address bits A1 and A0, then data bits D9 down to D0. Each bit is sampled on a rising serial-clock edge. The data reaches the addressed register only after chip-select rises; the register holds its old value until then.
- R3: If chip-select rises before the thirteenth bit of a write frame has been sampled, every register keeps its value.
- R4: Serial-clock edges after the thirteenth bit of a write frame are ignored. The register receives the ten data bits that followed the address.
- R5: A read frame is a 1 flag followed by A1 and A0. Right after A0 is sampled, `spi_dout_oe` goes to 1 and `spi_dout` shows D9. Each later falling edge of the serial clock advances one bit, most significant bit first. A read changes no register.
- R6: `spi_dout_oe` returns to 0 on the falling serial-clock edge that follows the tenth output bit. It stays 0 for any further clocks in that frame.
- R7: If chip-select rises while a read is under way, `spi_dout_oe` goes to 0 within the synchronizer delay plus one clock.
- R8: A write to address 3 stores only data bit 9, into `sense_en`. Bits 8 to 0 are discarded, and addresses 0 to 2 are not touched.
- R9: A read of address 3 returns `sense_en` at bit 9, zeros at bits 8 to 1, and the synchronized level of `cmp_in` at bit 0.
- R10: A read of addresses 0, 1 or 2 returns the value last written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_din | input | 1 | Serial data from the host |
| cmp_in | input | 1 | Comparator level returned in address-3 reads |
| spi_dout | output | 1 | Serial read data |
| spi_dout_oe | output | 1 | Drive enable for the data output pad; 0 means high impedance |
| ctl_reg0 | output | DATA_W | Contents of address 0 |
| ctl_reg1 | output | DATA_W | Contents of address 1 |
| ctl_reg2 | output | DATA_W | Contents of address 2 |
| sense_en | output | 1 | Sense-enable flag held at address 3 |

## Verification
Writes and reads use alternating-bit, all-ones and single-bit data words. These patterns show up a bit-order reversal, an off-by-one shift, and a stuck output bit. Frames cut after three and after twelve clocks show whether a partial write can leak into a register. A frame with three extra clocks shows whether the data window slides. Address-3 traffic is run with the comparator at both levels and with data whose bit 9 differs from its lower bits. Reads aborted mid-word check the output-enable timing against the chip-select rise.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;

    localparam int REG_BITS  = 10;
    localparam int ADDR_BITS = 2;
    localparam int HDR_BITS  = 1 + ADDR_BITS;
    localparam int NUM_ADDR  = 1 << ADDR_BITS;
    localparam int NUM_WORDS = NUM_ADDR - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WDATA,
        ST_WFULL,
        ST_RDATA,
        ST_RDONE
    } frame_state_t;

endpackage

// File: rtl/ser_pin_sync.sv
module ser_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_raw,
    input  logic sclk_raw,
    input  logic din_raw,
    input  logic cmp_raw,
    output logic cs_lvl,
    output logic din_lvl,
    output logic cmp_lvl,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_rise
);
    localparam int PINS = 4;
    localparam int P_CS = 3;
    localparam int P_SCLK = 2;
    localparam int P_DIN = 1;
    localparam int P_CMP = 0;
    localparam logic [PINS-1:0] IDLE_VEC = 4'b1000;

    logic [STAGES-1:0][PINS-1:0] chain;
    logic [PINS-1:0]             last;
    logic                        cs_prev;
    logic                        sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= IDLE_VEC;
        end else begin
            chain[0] <= {cs_n_raw, sclk_raw, din_raw, cmp_raw};
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign last = chain[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= last[P_CS];
            sclk_prev <= last[P_SCLK];
        end
    end

    assign cs_lvl    = last[P_CS];
    assign din_lvl   = last[P_DIN];
    assign cmp_lvl   = last[P_CMP];
    assign sclk_rise = last[P_SCLK] & ~sclk_prev;
    assign sclk_fall = ~last[P_SCLK] & sclk_prev;
    assign cs_rise   = last[P_CS] & ~cs_prev;

endmodule

// File: rtl/ser_frame_fsm.sv
module ser_frame_fsm
    import ser_reg_pkg::*;
#(
    parameter int DATA_W = REG_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_lvl,
    input  logic                 cs_rise,
    input  logic                 sclk_rise,
    input  logic                 sclk_fall,
    input  logic                 din_lvl,
    input  logic [DATA_W-1:0]    rd_word,
    output logic [ADDR_BITS-1:0] rd_addr,
    output logic                 wr_en,
    output logic [ADDR_BITS-1:0] wr_addr,
    output logic [DATA_W-1:0]    wr_data,
    output logic                 dout,
    output logic                 dout_oe
);
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int FL_W       = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [FL_W-1:0]  FALL_LOAD  = FL_W'(DATA_W + 1);
    localparam logic [FL_W-1:0]  FALL_ONE   = FL_W'(1);

    frame_state_t           state;
    frame_state_t           state_nx;
    logic [CNT_W-1:0]       bit_cnt;
    logic [ADDR_BITS-1:0]   hdr_sr;
    logic [DATA_W-1:0]      data_sr;
    logic [DATA_W-1:0]      tx_sr;
    logic [FL_W-1:0]        fall_left;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: SEL_LOW, HDR_WRITE, HDR_READ, WR_FULL, RD_DONE, DESELECT
    always_comb begin
        state_nx = state;
        if (cs_lvl) begin
            state_nx = ST_IDLE;                              // DESELECT
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_HDR;                 // SEL_LOW
                ST_HDR: begin
                    if (sclk_rise && bit_cnt == HDR_LAST)
                        state_nx = hdr_sr[1] ? ST_RDATA      // HDR_READ
                                             : ST_WDATA;     // HDR_WRITE
                end
                ST_WDATA: begin
                    if (sclk_rise && bit_cnt == FRAME_LAST)
                        state_nx = ST_WFULL;                 // WR_FULL
                end
                ST_WFULL: state_nx = ST_WFULL;
                ST_RDATA: begin
                    if (sclk_fall && fall_left == FALL_ONE)
                        state_nx = ST_RDONE;                 // RD_DONE
                end
                ST_RDONE: state_nx = ST_RDONE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            hdr_sr    <= '0;
            data_sr   <= '0;
            tx_sr     <= '0;
            fall_left <= '0;
            dout_oe   <= 1'b0;
        end else if (cs_lvl) begin
            bit_cnt   <= '0;
            fall_left <= '0;
            dout_oe   <= 1'b0;
        end else begin
            unique case (state)
                ST_HDR: begin
                    if (sclk_rise) begin
                        hdr_sr  <= {hdr_sr[0], din_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == HDR_LAST && hdr_sr[1]) begin
                            tx_sr     <= rd_word;
                            dout_oe   <= 1'b1;
                            fall_left <= FALL_LOAD;
                        end
                    end
                end
                ST_WDATA: begin
                    if (sclk_rise) begin
                        data_sr <= {data_sr[DATA_W-2:0], din_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (sclk_fall) begin
                        if (fall_left == FALL_ONE) begin
                            dout_oe   <= 1'b0;
                            fall_left <= '0;
                        end else begin
                            // first fall after the load keeps the top bit
                            if (fall_left != FALL_LOAD)
                                tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                            fall_left <= fall_left - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign rd_addr = {hdr_sr[0], din_lvl};
    assign wr_addr = hdr_sr;
    assign wr_data = data_sr;
    assign wr_en   = (state == ST_WFULL) && cs_rise;
    assign dout    = tx_sr[DATA_W-1];

endmodule

// File: rtl/ser_reg_bank.sv
module ser_reg_bank
    import ser_reg_pkg::*;
#(
    parameter int DATA_W = REG_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_BITS-1:0]        wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [ADDR_BITS-1:0]        rd_addr,
    input  logic                        cmp_lvl,
    output logic [NUM_WORDS*DATA_W-1:0] words,
    output logic                        sense_flag,
    output logic [DATA_W-1:0]           rd_word
);
    localparam logic [ADDR_BITS-1:0] SENSE_ADDR = ADDR_BITS'(NUM_ADDR - 1);

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_addr == ADDR_BITS'(g))
                q <= wr_data;
        end
        assign words[g*DATA_W +: DATA_W] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sense_flag <= 1'b0;
        else if (wr_en && wr_addr == SENSE_ADDR)
            sense_flag <= wr_data[DATA_W-1];
    end

    always_comb begin
        if (rd_addr == SENSE_ADDR)
            rd_word = {sense_flag, {(DATA_W-2){1'b0}}, cmp_lvl};
        else
            rd_word = words[int'(rd_addr)*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/ser_reg_slave.sv
module ser_reg_slave
    import ser_reg_pkg::*;
#(
    parameter int DATA_W      = REG_BITS,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_din,
    input  logic              cmp_in,
    output logic              spi_dout,
    output logic              spi_dout_oe,
    output logic [DATA_W-1:0] ctl_reg0,
    output logic [DATA_W-1:0] ctl_reg1,
    output logic [DATA_W-1:0] ctl_reg2,
    output logic              sense_en
);
    logic                        cs_lvl;
    logic                        din_lvl;
    logic                        cmp_lvl;
    logic                        sclk_rise;
    logic                        sclk_fall;
    logic                        cs_rise;
    logic [ADDR_BITS-1:0]        rd_addr;
    logic [DATA_W-1:0]           rd_word;
    logic                        wr_en;
    logic [ADDR_BITS-1:0]        wr_addr;
    logic [DATA_W-1:0]           wr_data;
    logic [NUM_WORDS*DATA_W-1:0] words;

    ser_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_raw  (spi_cs_n),
        .sclk_raw  (spi_sclk),
        .din_raw   (spi_din),
        .cmp_raw   (cmp_in),
        .cs_lvl    (cs_lvl),
        .din_lvl   (din_lvl),
        .cmp_lvl   (cmp_lvl),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_rise   (cs_rise)
    );

    ser_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_lvl    (cs_lvl),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din_lvl   (din_lvl),
        .rd_word   (rd_word),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dout      (spi_dout),
        .dout_oe   (spi_dout_oe)
    );

    ser_reg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .cmp_lvl    (cmp_lvl),
        .words      (words),
        .sense_flag (sense_en),
        .rd_word    (rd_word)
    );

    assign ctl_reg0 = words[0*DATA_W +: DATA_W];
    assign ctl_reg1 = words[1*DATA_W +: DATA_W];
    assign ctl_reg2 = words[2*DATA_W +: DATA_W];

endmodule

// File: rtl/ser_reg_slave_chk.sv
module ser_reg_slave_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_lvl,
    input logic              cs_rise,
    input logic              sclk_rise,
    input logic              sclk_fall,
    input logic              spi_dout_oe,
    input logic [DATA_W-1:0] ctl_reg0,
    input logic [DATA_W-1:0] ctl_reg1,
    input logic [DATA_W-1:0] ctl_reg2,
    input logic              sense_en
);
    localparam int FC_W = $clog2(DATA_W + 3);

    logic [FC_W-1:0] fall_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           fall_cnt <= '0;
        else if (!spi_dout_oe) fall_cnt <= '0;
        else if (sclk_fall)    fall_cnt <= fall_cnt + 1'b1;
    end

    AST_REGS_HOLD_NO_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable({ctl_reg0, ctl_reg1, ctl_reg2, sense_en})); // R3

    AST_OE_RISES_ON_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_dout_oe) |-> $past(sclk_rise)); // R5

    AST_OE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_dout_oe) |-> ($past(sclk_fall) || $past(cs_lvl))); // R6

    AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> !spi_dout_oe); // R7

    AST_TX_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_dout_oe |-> (fall_cnt <= FC_W'(DATA_W + 1))); // R6

endmodule

bind ser_reg_slave ser_reg_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_lvl      (cs_lvl),
    .cs_rise     (cs_rise),
    .sclk_rise   (sclk_rise),
    .sclk_fall   (sclk_fall),
    .spi_dout_oe (spi_dout_oe),
    .ctl_reg0    (ctl_reg0),
    .ctl_reg1    (ctl_reg1),
    .ctl_reg2    (ctl_reg2),
    .sense_en    (sense_en)
);

// File: tb/tb_ser_reg_slave.sv
module tb_ser_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 10;
    localparam int HALF = 8;   // system clocks per serial half period
    localparam int FB   = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic din = 1'b0;
    logic cmp = 1'b0;
    logic dout;
    logic oe;
    logic [DW-1:0] r0, r1, r2;
    logic sen;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] m0 = '0, m1 = '0, m2 = '0;
    logic          msen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_reg_slave dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
        .spi_din(din), .cmp_in(cmp), .spi_dout(dout), .spi_dout_oe(oe),
        .ctl_reg0(r0), .ctl_reg1(r1), .ctl_reg2(r2), .sense_en(sen)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        check(req, {22'd0, r0}, {22'd0, m0});
        check(req, {22'd0, r1}, {22'd0, m1});
        check(req, {22'd0, r2}, {22'd0, m2});
        check(req, {31'd0, sen}, {31'd0, msen});
    endtask

    // Drives nclk serial clocks of word w (bits past 13 are 1s); leaves CS low.
    // rx collects DOUT at slots 3..12; oe_cnt counts slots with OE high.
    task automatic clock_bits(input logic [FB-1:0] w, input int nclk,
                              output logic [DW-1:0] rx, output int oe_cnt);
        rx = '0;
        oe_cnt = 0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nclk; i++) begin
            din = (i < FB) ? w[FB-1-i] : 1'b1;
            wait_clk(HALF);
            if (oe) oe_cnt++;
            if (i >= 3 && i < FB) rx[FB-1-i] = dout;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
    endtask

    task automatic deselect();
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic spi_write(input logic [1:0] a, input logic [DW-1:0] d, input int nclk);
        logic [DW-1:0] rx;
        int oc;
        clock_bits({1'b0, a, d}, nclk, rx, oc);
        deselect();
    endtask

    task automatic spi_read(input logic [1:0] a, output logic [DW-1:0] rx,
                            output int oc, output logic oe_end);
        clock_bits({1'b1, a, 10'h000}, FB, rx, oc);
        oe_end = oe;
        deselect();
    endtask

    task automatic t_reset();
        check_regs("R1 reset regs");
        check("R1 reset oe", {31'd0, oe}, 32'd0);
    endtask

    task automatic t_write_basic();
        logic [DW-1:0] rx;
        int oc;
        clock_bits({1'b0, 2'd0, 10'h2A5}, FB, rx, oc);
        check("R2 held before CS rise", {22'd0, r0}, 32'd0);
        deselect();
        m0 = 10'h2A5;
        check_regs("R2 write addr0");
        spi_write(2'd1, 10'h15A, FB); m1 = 10'h15A;
        check_regs("R2 write addr1");
        spi_write(2'd2, 10'h3FF, FB); m2 = 10'h3FF;
        check_regs("R2 write addr2");
    endtask

    task automatic t_readback();
        logic [DW-1:0] rx;
        int oc;
        logic oend;
        spi_read(2'd0, rx, oc, oend);
        check("R10 read addr0", {22'd0, rx}, {22'd0, m0});
        check("R5 oe slots", oc, 32'd10);
        check("R6 oe off after 10 bits", {31'd0, oend}, 32'd0);
        spi_read(2'd1, rx, oc, oend);
        check("R10 read addr1", {22'd0, rx}, {22'd0, m1});
        spi_read(2'd2, rx, oc, oend);
        check("R10 read addr2", {22'd0, rx}, {22'd0, m2});
        check_regs("R5 read leaves regs");
        spi_write(2'd0, 10'h001, FB); m0 = 10'h001;
        spi_read(2'd0, rx, oc, oend);
        check("R5 single-bit word order", {22'd0, rx}, 32'h001);
    endtask

    task automatic t_short_write();
        spi_write(2'd1, 10'h0C3, FB - 1);
        check_regs("R3 12-clock frame dropped");
        spi_write(2'd2, 10'h000, 3);
        check_regs("R3 3-clock frame dropped");
    endtask

    task automatic t_extra_clocks();
        logic [DW-1:0] rx;
        int oc;
        logic oend;
        spi_write(2'd2, 10'h0F0, FB + 3); m2 = 10'h0F0;
        check_regs("R4 extra clocks ignored");
        clock_bits({1'b1, 2'd2, 10'h000}, FB + 3, rx, oc);
        check("R6 oe stays off on extra clocks", oc, 32'd10);
        check("R6 read data with extra clocks", {22'd0, rx}, 32'h0F0);
        deselect();
    endtask

    task automatic t_sense();
        logic [DW-1:0] rx;
        int oc;
        logic oend;
        spi_write(2'd3, 10'h3FF, FB); msen = 1'b1;
        check_regs("R8 addr3 stores bit9 only");
        cmp = 1'b1; wait_clk(4);
        spi_read(2'd3, rx, oc, oend);
        check("R9 addr3 read cmp=1", {22'd0, rx}, 32'h201);
        cmp = 1'b0; wait_clk(4);
        spi_read(2'd3, rx, oc, oend);
        check("R9 addr3 read cmp=0", {22'd0, rx}, 32'h200);
        spi_write(2'd3, 10'h1FF, FB); msen = 1'b0;
        check_regs("R8 bit9 clear, low bits dropped");
        cmp = 1'b1; wait_clk(4);
        spi_read(2'd3, rx, oc, oend);
        check("R9 addr3 read sense off", {22'd0, rx}, 32'h001);
    endtask

    task automatic t_abort_read();
        logic [DW-1:0] rx;
        int oc;
        clock_bits({1'b1, 2'd0, 10'h000}, 7, rx, oc);
        check("R7 oe on mid-read", {31'd0, oe}, 32'd1);
        cs_n = 1'b1;
        wait_clk(5);
        check("R7 oe off after CS rise", {31'd0, oe}, 32'd0);
        wait_clk(HALF);
        check_regs("R7 aborted read leaves regs");
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write_basic();
        t_readback();
        t_short_write();
        t_extra_clocks();
        t_sense();
        t_abort_read();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule